// File: doc/BRIEF.md
# Converter start pulse generator

This block turns a processor write into a clean, active-low start pulse for a successive-approximation converter whose logic is cleared while start is low and whose first bit decision is taken on the first falling clock edge after start returns high. It is meant for systems where the processor's own write strobe cannot drive the converter directly, for example when the processor clock is not available outside or runs too fast. A write counts only when the write request and the decoded converter-address select are both high at a rising edge of the local clock. The converter is assumed to run from the same clock, with its falling edge as the active edge.

Start is driven from a register that changes only on rising edges, so it is glitch-free and always returns high half a period away from any falling edge. It stays low for a whole number of cycles equal to the larger of two parameters: the cycles that cover the minimum clearing width and the cycles that cover the settling time needed before the first bit decision. After release the block counts a fixed number of further cycles and then raises a ready flag, telling the processor that the result may be read. A new write at any time restarts the whole sequence.

Top module: `spg_start_gen`

## Requirements
- R1: While rst_n is low, and for every cycle after its release until the first accepted write, start_n is 1 and ready is 0.
- R2: A write is accepted at a rising edge where wr_req and addr_sel are both 1; start_n is 0 from that edge on.
- R3: With no further accepted write, start_n returns to 1 exactly HOLD_CYC rising edges after the accepting edge, where HOLD_CYC is the larger of CLR_CYC and SETTLE_CYC (at least 1); start_n changes only at rising edges.
- R4: Writes accepted on several consecutive edges keep start_n low, and the release comes HOLD_CYC edges after the last of them.
- R5: ready rises exactly READ_CYC rising edges after start_n returns to 1, is never 1 while start_n is 0, and stays 1 until the next accepted write.
- R6: A write accepted while start_n is low or while the post-release count is running restarts the sequence: start_n is 0 after that edge and the R3 and R5 timing is measured from it.
- R7: A write accepted while ready is 1 clears ready at the same edge where start_n falls.
- R8: wr_req high with addr_sel low, or addr_sel high with wr_req low, changes neither start_n nor ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; rising edge updates the block, falling edge is the converter's active edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write request from the processor bus |
| addr_sel | input | 1 | Decoded converter address select |
| start_n | output | 1 | Active-low start pulse to the converter |
| ready | output | 1 | High when the conversion result may be read |

## Verification
The checker follows every cycle: an accepted write pulling start_n low and clearing ready on the next edge, a lone strobe or lone select never causing a falling start edge, start_n rising exactly the hold count after the last accepted write, ready rising exactly the hold plus read count after it, ready and a low start never coexisting, and ready holding until a new write. What the assertions cannot show is the whole sequence against an independent cycle model across reset, held writes, restarts placed inside the hold and inside the read wait, and writes arriving while ready; those come from the bench's directed scenarios and its long random run of sparse writes and stray strobes.

// File: rtl/spg_pkg.sv
`timescale 1ns/1ps
package spg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } spg_phase_e;

  function automatic int spg_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spg_rst_sync.sv
`timescale 1ns/1ps
module spg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/spg_cycle_timer.sv
`timescale 1ns/1ps
module spg_cycle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load | dec;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/spg_phase_ctrl.sv
`timescale 1ns/1ps
module spg_phase_ctrl
  import spg_pkg::*;
#(
  parameter int CW       = 9,
  parameter int HOLD_CYC = 375,
  parameter int READ_CYC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_load_val,
  output logic          tmr_dec,
  output logic          start_n,
  output logic          ready
);

  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] READ_LOAD = CW'(READ_CYC - 1);

  spg_phase_e phase_q;
  spg_phase_e phase_d;
  logic       start_n_q;
  logic       start_n_d;
  logic       ready_q;
  logic       ready_d;

  // next-state decode
  always_comb begin
    phase_d      = phase_q;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    tmr_dec      = 1'b0;
    if (trig) begin
      phase_d      = PH_HOLD;
      tmr_load     = 1'b1;
      tmr_load_val = HOLD_LOAD;
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          if (tmr_expired) begin
            phase_d      = PH_WAIT;
            tmr_load     = 1'b1;
            tmr_load_val = READ_LOAD;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        PH_WAIT: begin
          if (tmr_expired) begin
            phase_d = PH_DONE;
          end else begin
            tmr_dec = 1'b1;
          end
        end
        default: begin
          phase_d = phase_q;
        end
      endcase
    end
    start_n_d = (phase_d != PH_HOLD);
    ready_d   = (phase_d == PH_DONE);
  end

  // state and output registers, rising edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      start_n_q <= 1'b1;
      ready_q   <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      start_n_q <= start_n_d;
      ready_q   <= ready_d;
    end
  end

  assign start_n = start_n_q;
  assign ready   = ready_q;

endmodule

// File: rtl/spg_start_gen.sv
`timescale 1ns/1ps
module spg_start_gen
  import spg_pkg::*;
#(
  parameter int CLR_CYC    = 63,
  parameter int SETTLE_CYC = 375,
  parameter int READ_CYC   = 9,
  parameter int SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic addr_sel,
  output logic start_n,
  output logic ready
);

  localparam int HOLD_CYC = spg_max(spg_max(CLR_CYC, SETTLE_CYC), 1);
  localparam int WAIT_CYC = spg_max(READ_CYC, 1);
  localparam int CNT_MAX  = spg_max(HOLD_CYC, WAIT_CYC);
  localparam int CW       = $clog2(CNT_MAX + 1);

  logic          srst_n;
  logic          trig;
  logic          tmr_load;
  logic [CW-1:0] tmr_load_val;
  logic          tmr_dec;
  logic          tmr_expired;

  assign trig = wr_req & addr_sel;

  spg_rst_sync #(
    .STAGES (SYNC_STG)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  spg_cycle_timer #(
    .CW (CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .dec      (tmr_dec),
    .expired  (tmr_expired)
  );

  spg_phase_ctrl #(
    .CW       (CW),
    .HOLD_CYC (HOLD_CYC),
    .READ_CYC (WAIT_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (srst_n),
    .trig         (trig),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_load_val (tmr_load_val),
    .tmr_dec      (tmr_dec),
    .start_n      (start_n),
    .ready        (ready)
  );

endmodule

// File: rtl/spg_start_gen_chk.sv
`timescale 1ns/1ps
module spg_start_gen_chk #(
  parameter int HOLD_CYC = 375,
  parameter int READ_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic wr_req,
  input logic addr_sel,
  input logic start_n,
  input logic ready
);

  logic        acc;
  logic [31:0] since_q;

  assign acc = wr_req && addr_sel;

  // edges since the last accepted write, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '1;
    end else if (acc) begin
      since_q <= '0;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_accept_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !start_n);

  p_release_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_n) |-> (since_q == 32'(HOLD_CYC)));

  p_low_until_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && (since_q < 32'(HOLD_CYC - 1)) && !acc) |=> !start_n);

  p_ready_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (since_q == 32'(HOLD_CYC + READ_CYC)));

  p_ready_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && !start_n));

  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !acc) |=> ready);

  p_clear_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !ready);

  p_no_stray_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !$fell(start_n));

endmodule

bind spg_start_gen spg_start_gen_chk #(
  .HOLD_CYC (HOLD_CYC),
  .READ_CYC (WAIT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .wr_req   (wr_req),
  .addr_sel (addr_sel),
  .start_n  (start_n),
  .ready    (ready)
);

// File: tb/test_spg_start_gen.sv
`timescale 1ns/1ps
module test_spg_start_gen;

  localparam int CLR_CYC    = 63;
  localparam int SETTLE_CYC = 375;
  localparam int READ_CYC   = 9;
  localparam int HOLD_CYC   = (CLR_CYC > SETTLE_CYC) ? CLR_CYC : SETTLE_CYC;
  localparam int SEQ_CYC    = HOLD_CYC + READ_CYC;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_req;
  logic addr_sel;
  logic start_n;
  logic ready;

  int total = 0;
  int bad   = 0;
  int since = 0;
  bit ever  = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spg_start_gen #(
    .CLR_CYC    (CLR_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .READ_CYC   (READ_CYC)
  ) i_spg_start_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .addr_sel (addr_sel),
    .start_n  (start_n),
    .ready    (ready)
  );

  // expected values from R1, R3, R5: since = edges after the last accepted write
  function automatic logic exp_start(int s, bit e);
    return !(e && (s < HOLD_CYC));
  endfunction

  function automatic logic exp_ready(int s, bit e);
    return e && (s >= SEQ_CYC);
  endfunction

  task automatic check_bit(string what, string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // check outputs of the previous rising edge, then drive inputs for the next one
  task automatic step(bit wr, bit sel, string tag);
    @(negedge clk);
    check_bit("start_n", tag, start_n, exp_start(since, ever));
    check_bit("ready", tag, ready, exp_ready(since, ever));
    wr_req   = wr;
    addr_sel = sel;
    if (rst_n && wr && sel) begin
      since = 0;
      ever  = 1'b1;
    end else if (ever && (since < 1000000)) begin
      since++;
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  initial begin
    bit w;
    bit s;
    rst_n    = 1'b0;
    wr_req   = 1'b0;
    addr_sel = 1'b0;
    void'($urandom(32'h1A2B3C4D));

    idle(4, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(5, "R1 after release");

    // R8: lone strobe, lone select
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8 strobe only");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R8 select only");
    idle(2, "R8 idle");

    // R2, R3, R5: single write
    step(1'b1, 1'b1, "R2 single write");
    idle(SEQ_CYC + 5, "R3 R5 single sequence");

    // R8 while ready
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8 strobe while ready");
    step(1'b0, 1'b1, "R8 select while ready");
    idle(2, "R5 ready held");

    // R7: write while ready
    step(1'b1, 1'b1, "R7 write while ready");
    idle(SEQ_CYC + 3, "R7 sequence after ready");

    // R4: held write
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R4 held write");
    idle(SEQ_CYC + 3, "R4 stretched release");

    // R6: restart during read wait
    step(1'b1, 1'b1, "R6 first write");
    idle(HOLD_CYC + 3, "R6 into read wait");
    step(1'b1, 1'b1, "R6 restart in wait");
    idle(SEQ_CYC + 3, "R6 restarted sequence");

    // R6: restart during hold
    step(1'b1, 1'b1, "R6 first write");
    idle(100, "R6 inside hold");
    step(1'b1, 1'b1, "R6 restart in hold");
    idle(SEQ_CYC + 3, "R6 restarted from hold");

    // random sparse writes and stray strobes
    for (int i = 0; i < 20000; i++) begin
      w = ($urandom_range(0, 149) == 0);
      s = $urandom_range(0, 1);
      step(w, s, "R3 R5 R8 random");
    end
    idle(SEQ_CYC + 3, "R5 random tail");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule